// File: doc/BRIEF.md
# Error Event Status and Interrupt Register Block

This block gathers six error events reported by a link controller and holds each in a sticky status bit until software clears it. Each event arrives as a single-cycle pulse. Software sees two views of the held events through a 32-bit register port. The raw view shows every held event. The masked view shows only the events whose enable bit is set.

The enable mask is never written whole. One register address sets the enable bits written as 1, and another address clears them. Bits written as 0 are left alone. Writing 1s to the masked-view address clears the matching held events.

The block drives two outputs. `err_irq` is high while any held event is enabled. `fatal_irq` is high while an enabled event of the fatal class is held; that class is the fatal-error source and the tag-lookup source.

Reads are combinational from the address. A write takes effect at the rising clock edge where `bus_wen` is high.

Top module: `err_stat_top`

## Requirements
- R1: After reset, and after any later reset, the held events and the enable mask are zero, and both interrupt outputs are low.
- R2: A pulse on `evt_pulse[i]` sets held bit i at that clock edge, and the bit stays set until it is cleared. The bit positions are: 0 system error, 1 fatal, 2 non-fatal, 3 correctable, 4 tag-lookup fatal, 5 CRC error.
- R3: A read of offset 0x1C0 returns every held event in bits 5..0, whatever the enable mask holds.
- R4: A read of offset 0x1C4 returns the held events ANDed with the enable mask.
- R5: A write to 0x1C4 clears the held bits whose data bit is 1 and leaves every other held bit unchanged.
- R6: A write to 0x1C8 sets the enable bits whose data bit is 1 and leaves the others unchanged.
- R7: A write to 0x1CC clears the enable bits whose data bit is 1 and leaves the others unchanged.
- R8: A read of either 0x1C8 or 0x1CC returns the current enable mask.
- R9: `err_irq` is high exactly when the held events ANDed with the enable mask are non-zero.
- R10: `fatal_irq` is high exactly when bit 1 or bit 4 is both held and enabled.
- R11: If an event pulse and a write-1-clear of the same bit fall on the same clock edge, the bit stays set.
- R12: Read data bits 31..6 are always zero. Writes to 0x1C0 and to unmapped offsets have no effect. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Register byte offset |
| bus_wen | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_pulse | input | 6 | Single-cycle error event pulses |
| err_irq | output | 1 | Any enabled held event |
| fatal_irq | output | 1 | Any enabled held event of the fatal class |

## Verification
The assertions check on every cycle that:
- a pulsed event is held on the next edge, even when a clear hits the same bit;
- no held bit changes unless it was pulsed or written;
- enable set and clear writes land on exactly the written bits;
- the upper read bits stay zero;
- `err_irq` agrees with the masked view and covers `fatal_irq`.

Some behaviour depends on a whole sequence of operations, and only the bench's scenarios can show it:
- the raw view keeps events that were masked off;
- a later enable exposes an event that was held while masked;
- a re-enable restores `fatal_irq`;
- writes to the raw offset, to unmapped offsets and to the upper data bits leave no trace;
- a reset in the middle of a run returns every register to zero.

// File: rtl/err_stat_pkg.sv
package err_stat_pkg;

    localparam int NUM_SRC = 6;

    typedef enum int {
        SRC_SYSTEM     = 0,
        SRC_FATAL      = 1,
        SRC_NONFATAL   = 2,
        SRC_CORR       = 3,
        SRC_TAG_LOOKUP = 4,
        SRC_CRC        = 5
    } src_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    // Sources that count toward the fatal summary output.
    localparam src_vec_t FATAL_CLASS =
        src_vec_t'((1 << SRC_FATAL) | (1 << SRC_TAG_LOOKUP));

endpackage

// File: rtl/err_src_latch.sv
module err_src_latch #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] status_o
);

    typedef struct packed {
        logic [N-1:0] status;
    } state_t;

    state_t       st_d, st_q;
    logic [N-1:0] bit_next;

    // Per-bit next value: a new event wins over a clear on the same edge.
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign bit_next[i] = evt_i[i] | (st_q.status[i] & ~clr_i[i]);
    end

    always_comb begin
        st_d        = st_q;
        st_d.status = bit_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;

    AST_EVT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((status_o & $past(evt_i)) == $past(evt_i))); // R2

    AST_CLR_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i & clr_i) != '0) |=> ((status_o & $past(evt_i & clr_i)) == $past(evt_i & clr_i))); // R11

    AST_UNTOUCHED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & ~$past(evt_i | clr_i)) == ($past(status_o) & ~$past(evt_i | clr_i)))); // R5

endmodule

// File: rtl/err_enable_reg.sv
module err_enable_reg #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] enable_o
);

    typedef struct packed {
        logic [N-1:0] enable;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.enable = (st_q.enable | set_i) & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enable_o = st_q.enable;

    AST_EN_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0 && clr_i == '0) |=> ((enable_o & $past(set_i)) == $past(set_i))); // R6

    AST_EN_CLR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((enable_o & $past(clr_i)) == '0)); // R7

    AST_EN_OTHERS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((enable_o & ~$past(set_i | clr_i)) == ($past(enable_o) & ~$past(set_i | clr_i)))); // R6

endmodule

// File: rtl/err_bus_decode.sv
module err_bus_decode #(
    parameter int              N        = 6,
    parameter int              ADDR_W   = 12,
    parameter int              DATA_W   = 32,
    parameter logic [ADDR_W-1:0] RAW_OFS  = 12'h1C0,
    parameter logic [ADDR_W-1:0] MASK_OFS = 12'h1C4,
    parameter logic [ADDR_W-1:0] ESET_OFS = 12'h1C8,
    parameter logic [ADDR_W-1:0] ECLR_OFS = 12'h1CC
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wen_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [N-1:0]      raw_i,
    input  logic [N-1:0]      en_i,
    output logic [N-1:0]      stat_clr_o,
    output logic [N-1:0]      en_set_o,
    output logic [N-1:0]      en_clr_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int PAD_W = DATA_W - N;

    logic [N-1:0] wbits;
    logic         unused_wdata_hi;

    assign wbits           = wdata_i[N-1:0];
    assign unused_wdata_hi = ^wdata_i[DATA_W-1:N];

    always_comb begin
        stat_clr_o = '0;
        en_set_o   = '0;
        en_clr_o   = '0;
        if (wen_i) begin
            if (addr_i == MASK_OFS) stat_clr_o = wbits;
            if (addr_i == ESET_OFS) en_set_o   = wbits;
            if (addr_i == ECLR_OFS) en_clr_o   = wbits;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == RAW_OFS)
            rdata_o = {{PAD_W{1'b0}}, raw_i};
        else if (addr_i == MASK_OFS)
            rdata_o = {{PAD_W{1'b0}}, raw_i & en_i};
        else if (addr_i == ESET_OFS || addr_i == ECLR_OFS)
            rdata_o = {{PAD_W{1'b0}}, en_i};
    end

endmodule

// File: rtl/err_stat_top.sv
module err_stat_top
    import err_stat_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter int              DATA_W   = 32,
    parameter logic [ADDR_W-1:0] RAW_OFS  = 12'h1C0,
    parameter logic [ADDR_W-1:0] MASK_OFS = 12'h1C4,
    parameter logic [ADDR_W-1:0] ESET_OFS = 12'h1C8,
    parameter logic [ADDR_W-1:0] ECLR_OFS = 12'h1CC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] evt_pulse,
    output logic              err_irq,
    output logic              fatal_irq
);

    src_vec_t raw_q, en_q, stat_clr, en_set, en_clr, live;

    err_src_latch #(.N(NUM_SRC)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_pulse),
        .clr_i    (stat_clr),
        .status_o (raw_q)
    );

    err_enable_reg #(.N(NUM_SRC)) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (en_set),
        .clr_i    (en_clr),
        .enable_o (en_q)
    );

    err_bus_decode #(
        .N        (NUM_SRC),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .RAW_OFS  (RAW_OFS),
        .MASK_OFS (MASK_OFS),
        .ESET_OFS (ESET_OFS),
        .ECLR_OFS (ECLR_OFS)
    ) u_decode (
        .addr_i     (bus_addr),
        .wen_i      (bus_wen),
        .wdata_i    (bus_wdata),
        .raw_i      (raw_q),
        .en_i       (en_q),
        .stat_clr_o (stat_clr),
        .en_set_o   (en_set),
        .en_clr_o   (en_clr),
        .rdata_o    (bus_rdata)
    );

    assign live      = raw_q & en_q;
    assign err_irq   = |live;
    assign fatal_irq = |(live & FATAL_CLASS);

    AST_IRQ_MATCHES_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == MASK_OFS) |-> (err_irq == (bus_rdata != '0))); // R9

    AST_FATAL_IN_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_irq |-> err_irq); // R10

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_SRC] == '0); // R12

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!err_irq && !fatal_irq)); // R1

endmodule

// File: tb/err_stat_top_tb.sv
module err_stat_top_tb;

    localparam logic [11:0] A_RAW  = 12'h1C0;
    localparam logic [11:0] A_MASK = 12'h1C4;
    localparam logic [11:0] A_ESET = 12'h1C8;
    localparam logic [11:0] A_ECLR = 12'h1CC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  evt_pulse = '0;
    logic        err_irq, fatal_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    err_stat_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_pulse (evt_pulse),
        .err_irq   (err_irq),
        .fatal_irq (fatal_irq)
    );

    typedef struct packed {
        logic [5:0] evt;
        logic [5:0] eset;
        logic [5:0] eclr;
        logic [5:0] w1c;
        logic [5:0] raw;
        logic [5:0] en;
        logic [5:0] msk;
        logic       irq;
        logic       fat;
    } vec_t;

    // Each row: pulse, then enable set, enable clear, status clear; then compare.
    localparam vec_t VECS [9] = '{
        '{6'h01, 6'h00, 6'h00, 6'h00, 6'h01, 6'h00, 6'h00, 1'b0, 1'b0}, // R2 R3 masked-off event
        '{6'h00, 6'h3F, 6'h00, 6'h00, 6'h01, 6'h3F, 6'h01, 1'b1, 1'b0}, // R6 R9
        '{6'h02, 6'h00, 6'h00, 6'h00, 6'h03, 6'h3F, 6'h03, 1'b1, 1'b1}, // R10 fatal bit
        '{6'h00, 6'h00, 6'h00, 6'h03, 6'h00, 6'h3F, 6'h00, 1'b0, 1'b0}, // R5
        '{6'h10, 6'h00, 6'h10, 6'h00, 6'h10, 6'h2F, 6'h00, 1'b0, 1'b0}, // R7 R3
        '{6'h00, 6'h10, 6'h00, 6'h00, 6'h10, 6'h3F, 6'h10, 1'b1, 1'b1}, // R6 R10 tag lookup
        '{6'h2C, 6'h00, 6'h00, 6'h10, 6'h2C, 6'h3F, 6'h2C, 1'b1, 1'b0}, // R5 R4
        '{6'h00, 6'h00, 6'h2C, 6'h00, 6'h2C, 6'h13, 6'h00, 1'b0, 1'b0}, // R7 R4
        '{6'h00, 6'h3F, 6'h00, 6'h3F, 6'h00, 6'h3F, 6'h00, 1'b0, 1'b0}  // R5 R6
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // Called at a falling edge; applies one cycle of stimulus and returns at the next falling edge.
    task automatic step(input logic [11:0] a, input logic we, input logic [31:0] d, input logic [5:0] ev);
        bus_addr  = a;
        bus_wen   = we;
        bus_wdata = d;
        evt_pulse = ev;
        @(posedge clk);
        @(negedge clk);
        bus_wen   = 1'b0;
        evt_pulse = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_all(input string tag, input logic [5:0] raw, input logic [5:0] en,
                             input logic [5:0] msk, input logic irq, input logic fat);
        logic [31:0] v;
        rd(A_RAW, v);  check({tag, " R3 raw"}, v, {26'd0, raw});
        rd(A_MASK, v); check({tag, " R4 masked"}, v, {26'd0, msk});
        rd(A_ESET, v); check({tag, " R8 enable"}, v, {26'd0, en});
        check({tag, " R9 err_irq"}, {31'd0, err_irq}, {31'd0, irq});
        check({tag, " R10 fatal_irq"}, {31'd0, fatal_irq}, {31'd0, fat});
    endtask

    initial begin : watchdog
        #(8 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        check_all("R1 reset", 6'h00, 6'h00, 6'h00, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release", 6'h00, 6'h00, 6'h00, 1'b0, 1'b0);

        for (int i = 0; i < 9; i++) begin
            step(A_RAW, 1'b0, 32'd0, VECS[i].evt);
            if (VECS[i].eset != '0) step(A_ESET, 1'b1, {26'd0, VECS[i].eset}, 6'h00);
            if (VECS[i].eclr != '0) step(A_ECLR, 1'b1, {26'd0, VECS[i].eclr}, 6'h00);
            if (VECS[i].w1c  != '0) step(A_MASK, 1'b1, {26'd0, VECS[i].w1c}, 6'h00);
            check_all($sformatf("R2 row%0d", i), VECS[i].raw, VECS[i].en, VECS[i].msk,
                      VECS[i].irq, VECS[i].fat);
        end

        // R11: a pulse on bit 2 and a clear of bits 0 and 2 on the same edge
        step(A_RAW, 1'b0, 32'd0, 6'h01);
        step(A_MASK, 1'b1, 32'h0000_0005, 6'h04);
        rd(A_RAW, v); check("R11 pulse beats clear", v, 32'h0000_0004);

        // R12: a write to the raw offset is ignored
        step(A_RAW, 1'b1, 32'hFFFF_FFFF, 6'h00);
        rd(A_RAW, v); check("R12 raw write ignored", v, 32'h0000_0004);

        // R7 with all ones, the held event is kept, the interrupt drops
        step(A_ECLR, 1'b1, 32'hFFFF_FFFF, 6'h00);
        rd(A_ESET, v); check("R7 enable all cleared", v, 32'h0000_0000);
        rd(A_RAW, v);  check("R3 held while masked", v, 32'h0000_0004);
        check("R9 irq low when masked", {31'd0, err_irq}, 32'd0);

        // R12: upper write bits do not appear; R8: both enable offsets read the mask
        step(A_ESET, 1'b1, 32'hFFFF_FFFF, 6'h00);
        rd(A_ESET, v); check("R12 upper bits zero", v, 32'h0000_003F);
        rd(A_ECLR, v); check("R8 clear offset readback", v, 32'h0000_003F);
        check("R9 irq on re-enable", {31'd0, err_irq}, 32'd1);

        // R12: unmapped offset reads zero and a write there changes nothing
        step(12'h100, 1'b1, 32'hFFFF_FFFF, 6'h00);
        rd(12'h100, v); check("R12 unmapped reads zero", v, 32'h0000_0000);
        rd(A_RAW, v);   check("R12 unmapped write ignored", v, 32'h0000_0004);

        // R1: reset in the middle of a run
        step(A_RAW, 1'b0, 32'd0, 6'h12);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 mid-run reset", 6'h00, 6'h00, 6'h00, 1'b0, 1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule